// File: doc/BRIEF.md
# Conditional Set/Clear/Invert Unit

This unit decides whether one of sixteen branch-style conditions holds for the current arithmetic flags. From that decision it forms the new value of a byte or word destination for three kinds of operation: set-on-condition, clear-on-condition and invert-on-condition. A mask immediate selects the style of the operation. A zero mask gives a whole-value boolean result. A nonzero mask changes only the bits marked with ones, and only when the condition holds.

The enclosing datapath fetches the operand, presents one request per cycle with `in_valid`, and writes the result back. Operand fetch and write-back are outside this unit. The `met` output doubles as the branch-taken decision for conditional branches that share the same condition field. Results and `met` are registered, so they appear one cycle after the request.

Top module: `cond_sci_unit`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `in_valid` high and is low one clock after a cycle with `in_valid` low. While `rst_n` is low, `out_valid`, `met` and `result` are all 0.
- R2: The status byte `flags` carries N at bit 7, V at bit 6, Z at bit 1 and C at bit 0; its other bits are ignored. `met` follows the `cond` code: 1 is !C, 2 is C, 3 is !C|Z, 4 is C&!Z, 5 is N^V, 6 is !(N^V), 7 is Z|(N^V), 8 is !Z&!(N^V), 9 is Z, A is !Z, B is N, C is !N, D is !V, E is V.
- R3: Code 0 is always met and code F is never met, whatever the flags.
- R4: `op`=0 (set) with a zero mask yields the value 1 when met and 0 when not met.
- R5: `op`=1 (clear) with a zero mask yields 0 when met and 1 when not met.
- R6: `op`=2 (invert) with a zero mask yields the bitwise complement of `dest` when met and `dest` unchanged otherwise.
- R7: `op`=0 with a nonzero mask yields `dest | mask` when met.
- R8: `op`=1 with a nonzero mask yields `dest & ~mask` when met.
- R9: `op`=2 with a nonzero mask yields `dest ^ mask` when met.
- R10: With a nonzero mask and the condition not met, `result` equals `dest` for every op. For example, set on code 2 with mask 0x0088 sets bits 3 and 7 when C=1 and leaves the value alone when C=0.
- R11: With `wide`=0 (byte), only bits 7:0 take part. The mask counts as zero when its low 8 bits are zero, and `result[15:8]` equals `dest[15:8]`.
- R12: `op`=3 passes `dest` to `result` unchanged and still reports `met`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| cond | input | 4 | Condition code |
| op | input | 2 | 0 set, 1 clear, 2 invert, 3 pass |
| wide | input | 1 | 1 word operand, 0 byte operand |
| mask | input | 16 | Bit-select immediate, zero for boolean form |
| dest | input | 16 | Current destination value |
| flags | input | 8 | Status byte holding N, V, Z, C |
| out_valid | output | 1 | Result present |
| met | output | 1 | Condition held; also the branch-taken decision |
| result | output | 16 | New destination value |

## Verification
The only state is the output register stage. A wrong condition decode or a wrong operation mix therefore shows up at `met` or `result` in the very cycle after the offending request. Nothing stays hidden for later cycles. A valid flag dropped or duplicated in that stage shows up at once as an extra or missing result against the queue of expected items. Sweeping every condition against every flag combination, under both mask forms and both sizes, exposes any single wrong table entry within one pass.

// File: rtl/cond_sci_unit.sv
module cond_sci_unit #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    cond,
  input  logic [1:0]    op,
  input  logic          wide,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] dest,
  input  logic [7:0]    flags,
  output logic          out_valid,
  output logic          met,
  output logic [DW-1:0] result
);

  localparam logic [1:0] OP_SET = 2'd0;
  localparam logic [1:0] OP_CLR = 2'd1;
  localparam logic [1:0] OP_INV = 2'd2;

  logic fn, fv, fz, fc, slt, hit, mask_any;
  logic [DW-1:0] calc, nxt;

  assign fn  = flags[7];
  assign fv  = flags[6];
  assign fz  = flags[1];
  assign fc  = flags[0];
  assign slt = fn ^ fv;

  always_comb begin
    case (cond)
      4'h0: hit = 1'b1;
      4'h1: hit = ~fc;
      4'h2: hit = fc;
      4'h3: hit = ~fc | fz;
      4'h4: hit = fc & ~fz;
      4'h5: hit = slt;
      4'h6: hit = ~slt;
      4'h7: hit = fz | slt;
      4'h8: hit = ~fz & ~slt;
      4'h9: hit = fz;
      4'hA: hit = ~fz;
      4'hB: hit = fn;
      4'hC: hit = ~fn;
      4'hD: hit = ~fv;
      4'hE: hit = fv;
      default: hit = 1'b0;
    endcase
  end

  assign mask_any = wide ? |mask : |mask[BW-1:0];

  always_comb begin
    calc = dest;
    if (!mask_any) begin
      case (op)
        OP_SET: calc = hit ? DW'(1) : '0;
        OP_CLR: calc = hit ? '0 : DW'(1);
        OP_INV: calc = hit ? ~dest : dest;
        default: calc = dest;
      endcase
    end else if (hit) begin
      case (op)
        OP_SET: calc = dest | mask;
        OP_CLR: calc = dest & ~mask;
        OP_INV: calc = dest ^ mask;
        default: calc = dest;
      endcase
    end
  end

  assign nxt = wide ? calc : {dest[DW-1:BW], calc[BW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      met       <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      met       <= hit;
      result    <= nxt;
    end
  end

  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  always_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 4'h0) |=> met);
  // R3
  never_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 4'hF) |=> !met);
  // R11
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> result[DW-1:BW] == $past(dest[DW-1:BW]));
  // R10
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wide && mask != '0) |=> (met || result == $past(dest)));
  // R12
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd3) |=> result == $past(dest));

endmodule

// File: tb/test_cond_sci_unit.sv
module test_cond_sci_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  cond;
  logic [1:0]  op;
  logic        wide;
  logic [15:0] mask;
  logic [15:0] dest;
  logic [7:0]  flags;
  logic        out_valid;
  logic        met;
  logic [15:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  logic [16:0] exp_q[$];
  string       tag_q[$];

  cond_sci_unit i_cond_sci_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond(cond), .op(op),
    .wide(wide), .mask(mask), .dest(dest), .flags(flags),
    .out_valid(out_valid), .met(met), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic ref_met(input logic [3:0] c, input logic [7:0] f);
    logic n, v, z, cy;
    n = f[7]; v = f[6]; z = f[1]; cy = f[0];
    case (c)
      4'h0: return 1'b1;
      4'h1: return !cy;
      4'h2: return cy;
      4'h3: return !cy || z;
      4'h4: return cy && !z;
      4'h5: return n != v;
      4'h6: return n == v;
      4'h7: return z || (n != v);
      4'h8: return !z && (n == v);
      4'h9: return z;
      4'hA: return !z;
      4'hB: return n;
      4'hC: return !n;
      4'hD: return !v;
      4'hE: return v;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [16:0] ref_out(input logic [3:0] c, input logic [1:0] o,
      input logic w, input logic [15:0] m, input logic [15:0] d, input logic [7:0] f);
    logic hit;
    logic [15:0] lm, ld, r;
    hit = ref_met(c, f);
    lm = w ? m : {8'h00, m[7:0]};
    ld = w ? d : {8'h00, d[7:0]};
    r = ld;
    if (o == 2'd3) r = ld;
    else if (lm == 16'h0) begin
      if (o == 2'd0) r = hit ? 16'd1 : 16'd0;
      else if (o == 2'd1) r = hit ? 16'd0 : 16'd1;
      else r = hit ? ~ld : ld;
    end else if (hit) begin
      if (o == 2'd0) r = ld | lm;
      else if (o == 2'd1) r = ld & ~lm;
      else r = ld ^ lm;
    end
    if (!w) r = {d[15:8], r[7:0]};
    return {hit, r};
  endfunction

  function automatic string auto_tag(input logic [1:0] o, input logic w, input logic [15:0] m);
    logic z;
    z = w ? (m == 16'h0) : (m[7:0] == 8'h0);
    if (!w) return "R11";
    if (o == 2'd3) return "R12";
    if (z) return (o == 2'd0) ? "R4" : (o == 2'd1) ? "R5" : "R6";
    return (o == 2'd0) ? "R7" : (o == 2'd1) ? "R8" : "R9";
  endfunction

  task automatic drive(input logic [3:0] c, input logic [1:0] o, input logic w,
      input logic [15:0] m, input logic [15:0] d, input logic [7:0] f, input string tag);
    @(negedge clk);
    in_valid = 1'b1; cond = c; op = o; wide = w; mask = m; dest = d; flags = f;
    exp_q.push_back(ref_out(c, o, w, m, d, f));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R1: unexpected result, actual met=%0b result=%h expected none", met, result);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({met, result} !== e) begin
          n_bad++;
          $display("FAIL %s: actual met=%0b result=%h expected met=%0b result=%h",
                   t, met, result, e[16], e[15:0]);
        end
      end
    end
  end

  function automatic logic [7:0] mkflags(input logic [3:0] nvzc, input logic [3:0] junk);
    return {nvzc[3], nvzc[2], junk, nvzc[1], nvzc[0]};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; cond = '0; op = '0; wide = 1'b0;
    mask = '0; dest = '0; flags = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0 && met == 1'b0 && result == 16'h0, "R1",
          {15'h0, out_valid, met, result}, 32'h0);
    rst_n = 1'b1;

    // R10 example from the requirement: set on carry, mask 0x0088
    drive(4'h2, 2'd0, 1'b1, 16'h0088, 16'h1200, mkflags(4'b0001, 4'h0), "R10");
    drive(4'h2, 2'd0, 1'b1, 16'h0088, 16'h1200, mkflags(4'b0000, 4'h0), "R10");
    drive(4'h1, 2'd1, 1'b1, 16'h00F0, 16'hFFFF, mkflags(4'b0001, 4'h0), "R10");
    drive(4'h9, 2'd2, 1'b1, 16'h8001, 16'h5A5A, mkflags(4'b0000, 4'h0), "R10");
    // R3 always and never, with every flag value
    for (int f = 0; f < 16; f++) begin
      drive(4'h0, 2'd0, 1'b1, 16'h0, 16'h7777, mkflags(4'(f), 4'hF), "R3");
      drive(4'hF, 2'd0, 1'b1, 16'h0, 16'h7777, mkflags(4'(f), 4'hF), "R3");
    end
    idle(2);
    // R1 idle after stream
    check(out_valid == 1'b0, "R1", {31'h0, out_valid}, 32'h0);

    // R2 full condition table, junk in ignored flag bits
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        drive(4'(c), 2'd3, 1'b1, 16'h0, 16'hC3A5, mkflags(4'(f), 4'(c ^ f)), "R2");

    // R12 pass-through under byte and word
    drive(4'h9, 2'd3, 1'b0, 16'hFFFF, 16'hABCD, mkflags(4'b0010, 4'h0), "R12");
    drive(4'hA, 2'd3, 1'b1, 16'h0000, 16'h1357, mkflags(4'b0010, 4'h0), "R12");

    // R11 byte mask with only upper bits counts as zero
    drive(4'h0, 2'd0, 1'b0, 16'hFF00, 16'hBEEF, 8'h00, "R11");
    drive(4'h0, 2'd2, 1'b0, 16'hFF00, 16'hBE0F, 8'h00, "R11");

    // R4..R9, R11 sweep
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        for (int o = 0; o < 3; o++)
          for (int mi = 0; mi < 3; mi++)
            for (int w = 0; w < 2; w++) begin
              logic [15:0] mv;
              mv = (mi == 0) ? 16'h0000 : (mi == 1) ? 16'h0088 : 16'hA5F0;
              drive(4'(c), 2'(o), 1'(w), mv, 16'h3C69 ^ 16'(c * 16'h0111),
                    mkflags(4'(f), 4'h0), auto_tag(2'(o), 1'(w), mv));
            end
    idle(3);
    // R1 every pushed item was produced
    check(exp_q.size() == 0, "R1", exp_q.size(), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule